// File: doc/BRIEF.md
# Audio Clock Phase Flywheel Controller

This block chooses how a downstream audio sample clock regenerator is steered. As long as audio packets keep arriving with usable phase words, it reports a locked mode and the regenerator follows those phase words. When packets go missing or arrive damaged, the block does not give up at once. It coasts through a short run of lost packet slots in a flywheel mode. After that run is used up, it reports free-run, and the regenerator then derives the clock from the video format, the pixel clock and the frame-rate divisor flag M.

A packet slot counts as lost when either of two things happens. The first is a packet strobe that carries a corrupted packet or has no phase data. The second is no strobe at all within a programmable number of pixel clocks. The block also raises a status flag when packets arrive intact but without phase information. The host has two overrides. An ignore-phase control forces free-run. A force-M control replaces the detected M with a programmed value. The status flag never changes either override; only the host does.

All outputs are registered. They change one clock after the inputs that cause them. The asynchronous active-low reset is released through a two-stage synchronizer, so the block starts acting two clocks after `rst_n` rises.

Top module: `afc_flywheel_ctrl`

## Requirements
- R1: During reset and right after it, `mode_o` is 00 (free-run), `no_phase_o` is 0 and `m_sel_o` is 0.
- R2: `mode_o` encodes 00 as free-run, 01 as locked and 10 as flywheel. The value 11 never appears.
- R3: A good packet moves the mode to locked one clock later, from any mode, and clears the lost-slot run. A good packet is `pkt_stb`=1 with `pkt_ok`=1 and `phase_ok`=1, while `ignore_phase`=0.
- R4: A lost slot is either a strobe with `pkt_ok`=0 or `phase_ok`=0, or a timeout. While locked or flywheeling, each lost slot gives flywheel mode one clock later. Up to four consecutive lost slots keep the mode at flywheel.
- R5: The fifth consecutive lost slot since the last good packet moves the mode to free-run one clock later.
- R6: In free-run, lost slots have no effect. The mode stays 00 until a good packet arrives.
- R7: While `ignore_phase`=1, the mode is free-run one clock later. Good packets do not lock, whatever the value of `no_phase_o`.
- R8: A strobe with `pkt_ok`=1 and `phase_ok`=0 sets `no_phase_o` one clock later. A good packet clears it. Strobes with `pkt_ok`=0 and timeouts leave it unchanged. A set flag does not stop a later good packet from locking while `ignore_phase`=0.
- R9: `m_sel_o` equals `host_m` when `force_m`=1 and `det_m` otherwise, sampled one clock earlier.
- R10: A timeout occurs when no strobe is seen for `slot_len` clocks after the last strobe or the last timeout (`slot_len` ≥ 1). So with no further strobes, the first lost slot is recorded at the edge `slot_len` clocks after the strobe's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_stb | input | 1 | One-cycle pulse per received audio packet |
| pkt_ok | input | 1 | Packet arrived uncorrupted |
| phase_ok | input | 1 | Packet carries valid phase data |
| ignore_phase | input | 1 | Host control: force free-run |
| force_m | input | 1 | Host control: use programmed M |
| host_m | input | M_W | Host-programmed M value |
| det_m | input | M_W | M detected from the video |
| slot_len | input | CNT_W | Expected packet interval in pixel clocks |
| mode_o | output | 2 | 00 free-run, 01 locked, 10 flywheel |
| no_phase_o | output | 1 | Packets arrive without phase data |
| m_sel_o | output | M_W | M value selected for the clock regenerator |

## Verification
A wrong lost-slot count is visible directly on the mode output. The block drops to free-run one slot early or one slot late, and the error shows at the fifth lost slot, at most five slot intervals after the last good packet. A slot timer that is off by one moves the change from locked to flywheel by one clock, and that change can be seen `slot_len` clocks after a strobe. A bad status flag or M selection appears one clock after the packet or host input that should have changed it. The reference model compares all three outputs on every clock, so each of these faults is caught in the first cycle it appears.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_FLY  = 2'b10
  } afc_mode_e;

endpackage

// File: rtl/afc_slot_timer.sv
// Watches the gap between packet strobes. It emits a one-cycle timeout
// when slot_len clocks pass with no strobe, then starts counting again.
module afc_slot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_stb,
  input  logic [CNT_W-1:0] slot_len,
  output logic             slot_timeout
);

  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] gap_d;
  logic             gap_en;
  logic             at_limit;

  assign at_limit     = (gap_q == (slot_len - CNT_W'(1)));
  assign slot_timeout = !pkt_stb && at_limit;

  always_comb begin
    gap_en = 1'b1;
    if (pkt_stb || at_limit) begin
      gap_d = '0;
    end else begin
      gap_d = gap_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

endmodule

// File: rtl/afc_mode_fsm.sv
// Mode decision: locked, flywheel through a bounded run of lost slots,
// or free-run.
module afc_mode_fsm
  import afc_pkg::*;
#(
  parameter int FLY_MAX = 4,
  parameter int MISS_W  = $clog2(FLY_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              good_pkt,
  input  logic              slot_lost,
  input  logic              ignore_phase,
  output afc_mode_e         mode_q,
  output logic [MISS_W-1:0] miss_q
);

  localparam logic [MISS_W-1:0] MissLimit = MISS_W'(FLY_MAX);

  afc_mode_e         mode_d;
  logic [MISS_W-1:0] miss_d;
  logic              state_en;

  always_comb begin
    mode_d   = mode_q;
    miss_d   = miss_q;
    state_en = 1'b1;
    if (ignore_phase) begin
      mode_d = MODE_FREE;
      miss_d = '0;
    end else if (good_pkt) begin
      mode_d = MODE_LOCK;
      miss_d = '0;
    end else if (slot_lost) begin
      unique case (mode_q)
        MODE_LOCK: begin
          mode_d = MODE_FLY;
          miss_d = MISS_W'(1);
        end
        MODE_FLY: begin
          if (miss_q >= MissLimit) begin
            mode_d = MODE_FREE;
            miss_d = '0;
          end else begin
            miss_d = miss_q + MISS_W'(1);
          end
        end
        default: begin
          mode_d = MODE_FREE;
          miss_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      miss_q <= '0;
    end else if (state_en) begin
      mode_q <= mode_d;
      miss_q <= miss_d;
    end
  end

endmodule

// File: rtl/afc_phase_flag.sv
// Status flag: packets are arriving intact but without phase data.
module afc_phase_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_stb,
  input  logic pkt_ok,
  input  logic phase_ok,
  output logic flag_q
);

  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = pkt_stb && pkt_ok;
    flag_d  = !phase_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/afc_m_select.sv
// Registered choice between the detected and host-programmed M.
module afc_m_select #(
  parameter int M_W = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           force_m,
  input  logic [M_W-1:0] host_m,
  input  logic [M_W-1:0] det_m,
  output logic [M_W-1:0] m_q
);

  logic [M_W-1:0] m_d;
  logic           m_en;

  always_comb begin
    m_en = 1'b1;
    m_d  = force_m ? host_m : det_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
    end else if (m_en) begin
      m_q <= m_d;
    end
  end

endmodule

// File: rtl/afc_flywheel_ctrl.sv
module afc_flywheel_ctrl
  import afc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FLY_MAX = 4,
  parameter int M_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_stb,
  input  logic             pkt_ok,
  input  logic             phase_ok,
  input  logic             ignore_phase,
  input  logic             force_m,
  input  logic [M_W-1:0]   host_m,
  input  logic [M_W-1:0]   det_m,
  input  logic [CNT_W-1:0] slot_len,
  output logic [1:0]       mode_o,
  output logic             no_phase_o,
  output logic [M_W-1:0]   m_sel_o
);

  localparam int MISS_W = $clog2(FLY_MAX + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              slot_timeout;
  logic              good_pkt;
  logic              bad_pkt;
  logic              slot_lost;
  afc_mode_e         mode_q;
  logic [MISS_W-1:0] miss_q;

  assign good_pkt  = pkt_stb && pkt_ok && phase_ok;
  assign bad_pkt   = pkt_stb && !(pkt_ok && phase_ok);
  assign slot_lost = bad_pkt || slot_timeout;

  afc_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .pkt_stb      (pkt_stb),
    .slot_len     (slot_len),
    .slot_timeout (slot_timeout)
  );

  afc_mode_fsm #(.FLY_MAX(FLY_MAX), .MISS_W(MISS_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .good_pkt     (good_pkt),
    .slot_lost    (slot_lost),
    .ignore_phase (ignore_phase),
    .mode_q       (mode_q),
    .miss_q       (miss_q)
  );

  afc_phase_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pkt_stb  (pkt_stb),
    .pkt_ok   (pkt_ok),
    .phase_ok (phase_ok),
    .flag_q   (no_phase_o)
  );

  afc_m_select #(.M_W(M_W)) u_msel (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .force_m (force_m),
    .host_m  (host_m),
    .det_m   (det_m),
    .m_q     (m_sel_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/afc_flywheel_chk.sv
module afc_flywheel_chk #(
  parameter int M_W     = 1,
  parameter int MISS_W  = 3,
  parameter int FLY_MAX = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_stb,
  input logic              pkt_ok,
  input logic              phase_ok,
  input logic              ignore_phase,
  input logic              force_m,
  input logic [M_W-1:0]    host_m,
  input logic              slot_timeout,
  input logic [MISS_W-1:0] miss_q,
  input logic [1:0]        mode_o,
  input logic              no_phase_o,
  input logic [M_W-1:0]    m_sel_o
);

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  logic good;
  logic lost;
  assign good = pkt_stb && pkt_ok && phase_ok;
  assign lost = (pkt_stb && !(pkt_ok && phase_ok)) || slot_timeout;

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  a_r3_good_locks: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && good && !ignore_phase |=> mode_o == 2'b01);

  a_r4_lock_to_fly: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && mode_o == 2'b01 && lost && !ignore_phase |=> mode_o == 2'b10);

  a_r4_fly_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b10 |-> (miss_q >= MISS_W'(1)) && (miss_q <= MISS_W'(FLY_MAX)));

  a_r6_free_holds: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && mode_o == 2'b00 && !(good && !ignore_phase) |=> mode_o == 2'b00);

  a_r7_ignore_frees: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && ignore_phase |=> mode_o == 2'b00);

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && pkt_stb && pkt_ok && !phase_ok |=> no_phase_o);

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !(pkt_stb && pkt_ok) |=> $stable(no_phase_o));

  a_r9_forced_m: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && force_m |=> m_sel_o == $past(host_m));

endmodule

bind afc_flywheel_ctrl afc_flywheel_chk #(
  .M_W(M_W), .MISS_W(MISS_W), .FLY_MAX(FLY_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_q),
  .pkt_stb      (pkt_stb),
  .pkt_ok       (pkt_ok),
  .phase_ok     (phase_ok),
  .ignore_phase (ignore_phase),
  .force_m      (force_m),
  .host_m       (host_m),
  .slot_timeout (slot_timeout),
  .miss_q       (miss_q),
  .mode_o       (mode_o),
  .no_phase_o   (no_phase_o),
  .m_sel_o      (m_sel_o)
);

// File: tb/tb_afc_flywheel_ctrl.sv
module tb_afc_flywheel_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int M_W        = 1;

  logic             clk;
  logic             rst_n;
  logic             pkt_stb, pkt_ok, phase_ok;
  logic             ignore_phase, force_m;
  logic [M_W-1:0]   host_m, det_m;
  logic [CNT_W-1:0] slot_len;
  logic [1:0]       mode_o;
  logic             no_phase_o;
  logic [M_W-1:0]   m_sel_o;

  afc_flywheel_ctrl #(.CNT_W(CNT_W), .FLY_MAX(4), .M_W(M_W)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_stb(pkt_stb), .pkt_ok(pkt_ok),
    .phase_ok(phase_ok), .ignore_phase(ignore_phase), .force_m(force_m),
    .host_m(host_m), .det_m(det_m), .slot_len(slot_len),
    .mode_o(mode_o), .no_phase_o(no_phase_o), .m_sel_o(m_sel_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  // Behavioural reference model, updated on every rising edge.
  int       m_mode = 0;  // 0 free, 1 locked, 2 flywheel
  int       m_run  = 0;  // consecutive lost slots
  int       m_gap  = 0;  // clocks since last strobe or timeout
  bit       m_flag = 0;
  int       m_msel = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_gap = 0; m_flag = 0; m_msel = 0;
    end else begin
      bit good, lost, tmo;
      good = pkt_stb && pkt_ok && phase_ok;
      tmo  = 0;
      if (pkt_stb) m_gap = 0;
      else if (m_gap + 1 >= int'(slot_len)) begin tmo = 1; m_gap = 0; end
      else m_gap++;
      lost = (pkt_stb && !good) || tmo;
      if (ignore_phase) begin m_mode = 0; m_run = 0; end
      else if (good) begin m_mode = 1; m_run = 0; end
      else if (lost && m_mode != 0) begin
        m_run++;
        m_mode = (m_run > 4) ? 0 : 2;
        if (m_run > 4) m_run = 0;
      end
      if (pkt_stb && pkt_ok) m_flag = !phase_ok;
      m_msel = force_m ? int'(host_m) : int'(det_m);
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (int'(mode_o) != m_mode || no_phase_o != m_flag || int'(m_sel_o) != m_msel) begin
        n_fail++;
        $display("FAIL %s cycle compare: mode=%0d flag=%0d m=%0d expected mode=%0d flag=%0d m=%0d",
                 cur_req, mode_o, no_phase_o, m_sel_o, m_mode, m_flag, m_msel);
      end
    end
  end

  task automatic expect_out(input string req, input int mode_e, input int flag_e, input int m_e);
    n_checks++;
    if (int'(mode_o) != mode_e || int'(no_phase_o) != flag_e || int'(m_sel_o) != m_e) begin
      n_fail++;
      $display("FAIL %s: mode=%0d flag=%0d m=%0d expected mode=%0d flag=%0d m=%0d",
               req, mode_o, no_phase_o, m_sel_o, mode_e, flag_e, m_e);
    end
  endtask

  task automatic send(input bit ok, input bit ph);
    pkt_stb = 1'b1; pkt_ok = ok; phase_ok = ph;
    @(negedge clk);
    pkt_stb = 1'b0; pkt_ok = 1'b0; phase_ok = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pkt_stb = 0; pkt_ok = 0; phase_ok = 0;
    ignore_phase = 0; force_m = 0; host_m = '0; det_m = '0; slot_len = 16'd8;
    idle(4);
    expect_out("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    idle(5);
    expect_out("R1 after reset", 0, 0, 0);

    // R3: good packet locks; periodic packets keep lock.
    cur_req = "R3";
    send(1, 1);
    expect_out("R3 lock on good packet", 1, 0, 0);
    for (int i = 0; i < 6; i++) begin idle(5); send(1, 1); end
    expect_out("R3 stays locked with periodic packets", 1, 0, 0);

    // R10/R4/R5: timeouts after slot_len clocks.
    cur_req = "R10";
    idle(7);
    expect_out("R10 no timeout before slot_len", 1, 0, 0);
    idle(1);
    expect_out("R10 timeout at slot_len -> R4 flywheel", 2, 0, 0);
    cur_req = "R4";
    idle(24);
    expect_out("R4 fourth lost slot still flywheel", 2, 0, 0);
    idle(7);
    expect_out("R4 before fifth lost slot", 2, 0, 0);
    cur_req = "R5";
    idle(1);
    expect_out("R5 fifth lost slot -> free-run", 0, 0, 0);

    // R6: lost slots in free-run have no effect.
    cur_req = "R6";
    for (int i = 0; i < 3; i++) send(0, 1);
    idle(20);
    expect_out("R6 free-run unaffected by lost slots", 0, 0, 0);

    // R4/R3: corrupted packets flywheel, good packet relocks.
    cur_req = "R4";
    send(1, 1);
    for (int i = 0; i < 4; i++) send(0, 1);
    expect_out("R4 four corrupt packets flywheel", 2, 0, 0);
    send(1, 1);
    expect_out("R3 relock from flywheel", 1, 0, 0);
    cur_req = "R5";
    for (int i = 0; i < 5; i++) send(0, 0);
    expect_out("R5 five corrupt packets -> free-run, R8 flag kept", 0, 0, 0);

    // R8: phase-less packets set the flag; good packet clears it.
    cur_req = "R8";
    send(1, 1);
    send(1, 0);
    expect_out("R8 flag set by phase-less packet", 2, 1, 0);
    send(0, 0);
    expect_out("R8 corrupt packet keeps flag", 2, 1, 0);
    send(1, 1);
    expect_out("R8 good packet clears flag and locks", 1, 0, 0);
    for (int i = 0; i < 5; i++) send(1, 0);
    expect_out("R8 flag set, R5 free-run", 0, 1, 0);
    idle(30);
    expect_out("R8 timeouts keep flag", 0, 1, 0);
    send(1, 1);
    expect_out("R8 set flag does not imply ignore", 1, 0, 0);

    // R7: ignore-phase forces free-run.
    cur_req = "R7";
    ignore_phase = 1'b1;
    idle(1);
    expect_out("R7 ignore forces free-run", 0, 0, 0);
    send(1, 1); send(1, 1);
    expect_out("R7 good packets ignored", 0, 0, 0);
    ignore_phase = 1'b0;
    send(1, 1);
    expect_out("R7 release then lock", 1, 0, 0);

    // R9: M selection.
    cur_req = "R9";
    det_m = 1'b1; host_m = 1'b0;
    idle(1);
    expect_out("R9 detected M", 1, 0, 1);
    force_m = 1'b1;
    idle(1);
    expect_out("R9 forced M", 1, 0, 0);
    host_m = 1'b1; det_m = 1'b0;
    idle(1);
    expect_out("R9 forced M follows host", 1, 0, 1);
    force_m = 1'b0;
    idle(1);
    expect_out("R9 back to detected M", 1, 0, 0);

    // R10 boundary: slot_len of one.
    cur_req = "R10";
    slot_len = 16'd1;
    send(1, 1);
    idle(1);
    expect_out("R10 slot_len=1 first timeout", 2, 0, 0);
    idle(3);
    expect_out("R10 slot_len=1 fourth timeout", 2, 0, 0);
    idle(1);
    expect_out("R10 slot_len=1 fifth timeout R5", 0, 0, 0);

    cur_req = "R2";
    idle(3);
    finish_run();
  end

endmodule